// File: doc/BRIEF.md
# Latched Parallel Multiplexer Control Decoder

This block drives the switch-close signals of a four-input analog switch matrix that has two common terminals. A host presents a two-bit address, a switch enable, an active-low latch enable and a mode pin. The address and enable go through a latch. The latch passes them straight through while the latch enable is low and freezes them while it is high. A decoder turns the latched values into closures. The mode pin has two settings: one 1-of-4 multiplexer, or two 1-of-2 multiplexers that switch in step. The mode pin is not latched, so changing it reinterprets the held address immediately.

The block runs on a system clock. Both the latch and the switch outputs are registers clocked by it, and every input reaches the outputs one clock edge later. The active-low reset takes effect at once, with no clock needed. Its release is synchronised to the clock, and the outputs stay open for two further edges after the release.

Top module: `switch_matrix_ctl`

## Requirements
- R1: While `rst_n` is low, every bit of `sw_close` is 0 with no clock edge needed, and the held address and enable are cleared. After release with `le_n` kept high, all switches stay open.
- R2: While `le_n` is low, `addr` and `en` sampled at a clock edge decide `sw_close` right after that edge.
- R3: While `le_n` is high, `sw_close` follows the values present at the last edge at which `le_n` was low. Changes on `addr` and `en` have no effect.
- R4: A latched enable of 0 opens every switch, whatever the address and the mode.
- R5: With `pair_mode` = 0, address value k closes only `sw_close[k]`. Bits 0 and 1 connect inputs 1 and 2 to common 1. Bits 2 and 3 connect inputs 3 and 4 to common 2.
- R6: With `pair_mode` = 1, `addr[0]` = 0 closes bits 0 and 2, and `addr[0]` = 1 closes bits 1 and 3. `addr[1]` is ignored.
- R7: `pair_mode` is not latched. A change on it while `le_n` is high reinterprets the held address at the next edge.
- R8: At most one bit of `sw_close[1:0]` and at most one bit of `sw_close[3:2]` is ever 1.
- R9: After `rst_n` rises, `sw_close` stays 0 for two clock edges. The third edge loads the decoded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts immediately, releases on the clock |
| le_n | input | 1 | Latch enable, transparent when low |
| en | input | 1 | Switch enable, latched |
| addr | input | SEL_W | Channel address, latched |
| pair_mode | input | 1 | 0: one 1-of-4 mux, 1: two 1-of-2 muxes (not latched) |
| sw_close | output | 2**SEL_W | Switch-close per input path, bit i = input i+1 |

## Verification
Two things can land on the same clock edge: the latch closing and a change of the unlatched mode pin. The bench raises `le_n` while it also changes `addr`, `en` and `pair_mode` before the same edge. The outputs must then decode the address captured at the previous edge under the new mode. A reset that arrives in the middle of a hold also has to discard the held value. The bench releases it with the latch still closed and checks that no switch closes.

// File: rtl/switch_matrix_ctl_pkg.sv
package switch_matrix_ctl_pkg;

  typedef enum logic {
    MODE_QUAD = 1'b0,
    MODE_PAIR = 1'b1
  } mux_mode_e;

endpackage

// File: rtl/switch_matrix_ctl_rst_sync.sv
module switch_matrix_ctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/switch_matrix_ctl_latch.sv
module switch_matrix_ctl_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  // Capture on every edge while open; hold while closed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (!open_n) held <= d;
  end

  // Transparent path while open, held copy while closed.
  assign q = open_n ? held : d;
endmodule

// File: rtl/switch_matrix_ctl_decode.sv
module switch_matrix_ctl_decode
  import switch_matrix_ctl_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  mux_mode_e        mode,
  output logic [(1<<SEL_W)-1:0] close
);
  localparam int N    = 1 << SEL_W;
  localparam int HALF = N / 2;

  for (genvar i = 0; i < N; i++) begin : g_path
    localparam int LOW = i % HALF;
    logic hit_quad;
    logic hit_pair;
    assign hit_quad = (sel == SEL_W'(i));
    assign hit_pair = (sel[SEL_W-2:0] == (SEL_W-1)'(LOW));
    assign close[i] = en & ((mode == MODE_PAIR) ? hit_pair : hit_quad);
  end
endmodule

// File: rtl/switch_matrix_ctl.sv
module switch_matrix_ctl
  import switch_matrix_ctl_pkg::*;
#(
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int N          = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le_n,
  input  logic             en,
  input  logic [SEL_W-1:0] addr,
  input  logic             pair_mode,
  output logic [N-1:0]     sw_close
);
  localparam int LW = SEL_W + 1;

  logic          srst_n;
  logic [LW-1:0] lat_q;
  logic [N-1:0]  close_next;
  mux_mode_e     mode;

  switch_matrix_ctl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  switch_matrix_ctl_latch #(.W(LW)) u_lat (
    .clk    (clk),
    .rst_n  (srst_n),
    .open_n (le_n),
    .d      ({en, addr}),
    .q      (lat_q)
  );

  assign mode = mux_mode_e'(pair_mode);

  switch_matrix_ctl_decode #(.SEL_W(SEL_W)) u_dec (
    .en    (lat_q[LW-1]),
    .sel   (lat_q[SEL_W-1:0]),
    .mode  (mode),
    .close (close_next)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sw_close <= '0;
    else         sw_close <= close_next;
  end
endmodule

// File: rtl/switch_matrix_ctl_chk.sv
module switch_matrix_ctl_chk #(
  parameter int SEL_W = 2,
  localparam int N    = 1 << SEL_W,
  localparam int HALF = N / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             le_n,
  input logic             en,
  input logic [SEL_W-1:0] addr,
  input logic             pair_mode,
  input logic [N-1:0]     sw_close
);
  // R1: reset keeps every switch open
  p_reset_open_r1: assert property (@(posedge clk) !rst_n |-> sw_close == '0);

  // R8: one closure per common at most
  p_one_per_common_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_close[HALF-1:0]) && $onehot0(sw_close[N-1:HALF]));

  // R4: transparent disabled enable opens all
  p_disabled_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_n && !en) |=> sw_close == '0);

  // R3: closed latch with steady mode keeps outputs steady
  p_hold_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (le_n && $past(le_n) && pair_mode == $past(pair_mode)) |=> $stable(sw_close));

  // R5: single mode closes at most one path
  p_quad_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_mode |=> $countones(sw_close) <= 1);

  // R6: paired mode closes matching paths together
  p_pair_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_mode |=> sw_close[HALF-1:0] == sw_close[N-1:HALF]);
endmodule

bind switch_matrix_ctl switch_matrix_ctl_chk #(.SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .le_n      (le_n),
  .en        (en),
  .addr      (addr),
  .pair_mode (pair_mode),
  .sw_close  (sw_close)
);

// File: tb/switch_matrix_ctl_tb.sv
module switch_matrix_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       le_n = 1'b1;
  logic       en = 1'b0;
  logic [1:0] addr = 2'b00;
  logic       pair_mode = 1'b0;
  logic [3:0] sw_close;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  switch_matrix_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .le_n(le_n), .en(en),
    .addr(addr), .pair_mode(pair_mode), .sw_close(sw_close)
  );

  // {le_n, pair_mode, en, addr[1:0], expected sw_close[3:0], requirement}
  localparam logic [12:0] VEC [16] = '{
    13'b0_0_1_00_0001_0101, // R5 addr0 -> in1/com1
    13'b0_0_1_01_0010_0101, // R5
    13'b0_0_1_10_0100_0101, // R5
    13'b0_0_1_11_1000_0101, // R5
    13'b0_1_1_00_0101_0110, // R6
    13'b0_1_1_01_1010_0110, // R6
    13'b0_1_1_10_0101_0110, // R6 upper bit ignored
    13'b0_1_1_11_1010_0110, // R6
    13'b0_0_0_10_0000_0100, // R4
    13'b0_0_1_10_0100_0010, // R2
    13'b1_0_1_01_0100_0011, // R3 hold addr 10
    13'b1_0_0_11_0100_0011, // R3 en change ignored
    13'b1_1_0_00_0101_0111, // R7 mode reinterprets held 10
    13'b0_1_1_11_1010_0110, // R6
    13'b0_0_1_11_1000_0101, // R5
    13'b1_0_1_00_1000_0011  // R3 holds 11
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sw_close=%b expected %b", req, act, exp);
    end
  endtask

  task automatic check_r8();
    n_vec++;
    if (!$onehot0(sw_close[1:0]) || !$onehot0(sw_close[3:2])) begin
      n_bad++;
      $display("FAIL R8: sw_close=%b expected at most one per common", sw_close);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", sw_close, 4'b0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", sw_close, 4'b0000);

    for (int k = 0; k < 16; k++) begin
      {le_n, pair_mode, en, addr} = VEC[k][12:8];
      @(negedge clk);
      check(req_name(VEC[k][3:0]), sw_close, VEC[k][7:4]);
      check_r8();
    end

    // R1: reset takes effect without a clock edge
    le_n = 1'b0; pair_mode = 1'b0; en = 1'b1; addr = 2'b01;
    @(negedge clk);
    le_n = 1'b1;
    @(negedge clk);
    check("R3", sw_close, 4'b0010);
    #1 rst_n = 1'b0;
    #1 check("R1", sw_close, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: latch cleared, closed latch keeps everything open
    repeat (4) @(negedge clk);
    check("R1", sw_close, 4'b0000);

    // R9: release takes two edges before output loads
    rst_n = 1'b0;
    le_n = 1'b0; en = 1'b1; addr = 2'b11; pair_mode = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", sw_close, 4'b0000);
    @(negedge clk);
    check("R9", sw_close, 4'b0000);
    @(negedge clk);
    check("R9", sw_close, 4'b1000);

    // R3/R7: latch closes in the same cycle as addr, en and mode change
    addr = 2'b00;
    @(negedge clk);
    check("R2", sw_close, 4'b0001);
    le_n = 1'b1; addr = 2'b11; en = 1'b0; pair_mode = 1'b1;
    @(negedge clk);
    check("R7", sw_close, 4'b0101);
    check_r8();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule